// File: doc/BRIEF.md
# Transaction abort control unit

This unit holds the hardware transactional memory state of one core. When a transaction starts, it captures the address the program should resume at if the transaction fails. It also captures the stack pointer in force at that point. While the transaction runs, it watches three abort sources:

- a capacity overflow from the transactional cache;
- a data conflict reported by the cache;
- an explicit abort from the instruction stream.

When any of these arrives, the unit records which sources fired. It then issues a single redirect carrying the saved resume address and the saved stack pointer. No trap is taken.

Software can read four state registers through an index-selected read port that serves a move-from-TM instruction. A dedicated write strobe sets a 20-bit abort code that software keeps for its own bookkeeping. The pipeline consumes the redirect pulse and the new PC and SP. Retry decisions are left to software.

Top module: `tx_abort_ctrl`

## Requirements
- R1: After reset, active_o and redir_o are 0 and all four readable registers read as zero.
- R2: A begin strobe while no transaction is active latches beg_addr_i into register 0 and sp_i into register 1, and sets active_o from the next cycle on. A begin strobe while active has no effect.
- R3: A commit strobe while active clears active_o without a redirect. A commit strobe while inactive has no effect.
- R4: Overflow, conflict and explicit-abort inputs are ignored while no transaction is active: no redirect, and the cause register keeps its value.
- R5: Any abort source asserted while active gives, in the next cycle, redir_o high for exactly one cycle, redir_pc_o equal to register 0, redir_sp_o equal to register 1, and active_o low.
- R6: Register 2 (cause) is written only on an abort. It holds overflow in bit 0, conflict in bit 1 and explicit abort in bit 2, with all sources of that cycle set together and the upper bits zero. Several sources in one cycle still produce a single redirect.
- R7: Register 3 takes code_wdata_i (20 bits, zero-extended on read) when code_we_i is high, in any state. It keeps its value across begins, commits and aborts.
- R8: rd_data_o is combinational on rd_idx_i: 0 selects the abort address, 1 the saved stack pointer, 2 the cause, and 3 the code.
- R9: When a commit and an abort source coincide while active, the abort wins and a redirect is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beg_i | input | 1 | Transaction begin strobe |
| beg_addr_i | input | 32 | Abort resume address operand of begin |
| sp_i | input | 32 | Current stack pointer |
| commit_i | input | 1 | Commit strobe |
| xabort_i | input | 1 | Explicit abort strobe |
| ovf_i | input | 1 | Transactional cache overflow |
| conf_i | input | 1 | Data conflict from cache |
| code_we_i | input | 1 | Abort code write strobe |
| code_wdata_i | input | 20 | Abort code write data |
| rd_idx_i | input | 2 | Register read index |
| rd_data_o | output | 32 | Register read data |
| active_o | output | 1 | Transaction active |
| redir_o | output | 1 | Redirect pulse |
| redir_pc_o | output | 32 | Redirect target PC |
| redir_sp_o | output | 32 | Stack pointer to restore |

## Verification
The assertions check the following on every cycle:
- a redirect lasts one cycle and leaves the unit idle;
- no redirect follows an idle cycle;
- a redirect always carries a nonzero cause;
- the code register only changes under its strobe;
- a begin from idle captures its operand.

Some behaviours need the bench's reference model to show them:
- the exact cause bit pattern when sources coincide;
- abort winning over a simultaneous commit;
- register contents surviving aborts;
- the returned PC and SP values.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int CAUSE_W = 3;
  localparam int C_OVF   = 0;
  localparam int C_CONF  = 1;
  localparam int C_EXPL  = 2;

  typedef logic [CAUSE_W-1:0] cause_t;

  typedef enum logic [1:0] {
    TR_RESUME_PC = 2'd0,
    TR_SAVED_SP  = 2'd1,
    TR_CAUSE     = 2'd2,
    TR_CODE      = 2'd3
  } tm_reg_e;
endpackage

// File: rtl/tac_txstate.sv
module tac_txstate
  import tac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beg_i,
  input  logic [AW-1:0] beg_addr_i,
  input  logic [AW-1:0] sp_i,
  input  logic          commit_i,
  input  cause_t        raw_i,
  output logic          active_o,
  output logic          abort_ev_o,
  output logic [AW-1:0] resume_pc_o,
  output logic [AW-1:0] saved_sp_o
);
  logic          active_q, active_d;
  logic [AW-1:0] pc_q, sp_q;
  logic          cap_en;

  always_comb begin
    abort_ev_o = active_q & (|raw_i);
    cap_en     = ~active_q & beg_i;
    active_d   = active_q;
    if (abort_ev_o)               active_d = 1'b0;
    else if (active_q && commit_i) active_d = 1'b0;
    else if (cap_en)              active_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
    end else if (cap_en) begin
      pc_q <= beg_addr_i;
      sp_q <= sp_i;
    end
  end

  assign active_o    = active_q;
  assign resume_pc_o = pc_q;
  assign saved_sp_o  = sp_q;

  // R2: begin from idle captures its operands and opens the transaction
  a_r2_begin_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (beg_i && !active_q) |=> (active_q && pc_q == $past(beg_addr_i) && sp_q == $past(sp_i)));

  // R2: captured state is untouched while a transaction runs
  a_r2_hold_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> ($stable(pc_q) && $stable(sp_q)));
endmodule

// File: rtl/tac_cause.sv
module tac_cause
  import tac_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   abort_ev_i,
  input  cause_t raw_i,
  output cause_t cause_o,
  output logic   redir_o
);
  cause_t cause_q, cause_d;
  logic   redir_q;

  always_comb begin
    cause_d = cause_q;
    if (abort_ev_i) cause_d = raw_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      redir_q <= 1'b0;
    end else begin
      cause_q <= cause_d;
      redir_q <= abort_ev_i;
    end
  end

  assign cause_o = cause_q;
  assign redir_o = redir_q;

  // R6: a redirect always reports at least one cause
  a_r6_cause_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    redir_q |-> (cause_q != '0));

  // R6: cause only moves together with an abort
  a_r6_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_ev_i |=> $stable(cause_q));
endmodule

// File: rtl/tac_code_reg.sv
module tac_code_reg #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] code_o
);
  logic [CW-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (we_i) code_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;

  // R7: the code changes only under its write strobe
  a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(code_q));

  // R7: a write lands the data
  a_r7_code_write: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (code_q == $past(wdata_i)));
endmodule

// File: rtl/tx_abort_ctrl.sv
module tx_abort_ctrl
  import tac_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beg_i,
  input  logic [AW-1:0] beg_addr_i,
  input  logic [AW-1:0] sp_i,
  input  logic          commit_i,
  input  logic          xabort_i,
  input  logic          ovf_i,
  input  logic          conf_i,
  input  logic          code_we_i,
  input  logic [CW-1:0] code_wdata_i,
  input  logic [1:0]    rd_idx_i,
  output logic [AW-1:0] rd_data_o,
  output logic          active_o,
  output logic          redir_o,
  output logic [AW-1:0] redir_pc_o,
  output logic [AW-1:0] redir_sp_o
);
  localparam int CODE_PAD  = AW - CW;
  localparam int CAUSE_PAD = AW - CAUSE_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cause_t        raw;
  cause_t        cause;
  logic          abort_ev;
  logic [AW-1:0] resume_pc, saved_sp;
  logic [CW-1:0] code;
  logic [AW-1:0] code_ext, cause_ext;

  always_comb begin
    raw         = '0;
    raw[C_OVF]  = ovf_i;
    raw[C_CONF] = conf_i;
    raw[C_EXPL] = xabort_i;
  end

  tac_txstate #(.AW(AW)) u_state (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .beg_i       (beg_i),
    .beg_addr_i  (beg_addr_i),
    .sp_i        (sp_i),
    .commit_i    (commit_i),
    .raw_i       (raw),
    .active_o    (active_o),
    .abort_ev_o  (abort_ev),
    .resume_pc_o (resume_pc),
    .saved_sp_o  (saved_sp)
  );

  tac_cause u_cause (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .abort_ev_i (abort_ev),
    .raw_i      (raw),
    .cause_o    (cause),
    .redir_o    (redir_o)
  );

  tac_code_reg #(.CW(CW)) u_code (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_i    (code_we_i),
    .wdata_i (code_wdata_i),
    .code_o  (code)
  );

  generate
    if (CODE_PAD > 0) begin : g_code_pad
      assign code_ext = {{CODE_PAD{1'b0}}, code};
    end else begin : g_code_nopad
      assign code_ext = code[AW-1:0];
    end
  endgenerate
  assign cause_ext = {{CAUSE_PAD{1'b0}}, cause};

  always_comb begin
    case (tm_reg_e'(rd_idx_i))
      TR_RESUME_PC: rd_data_o = resume_pc;
      TR_SAVED_SP:  rd_data_o = saved_sp;
      TR_CAUSE:     rd_data_o = cause_ext;
      default:      rd_data_o = code_ext;
    endcase
  end

  assign redir_pc_o = resume_pc;
  assign redir_sp_o = saved_sp;

  // R5: redirect is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    redir_o |=> !redir_o);

  // R5: after a redirect the transaction is closed
  a_r5_closed_on_redirect: assert property (@(posedge clk) disable iff (!rst_int_n)
    redir_o |-> !active_o);

  // R4: no redirect can follow an idle cycle
  a_r4_idle_no_redirect: assert property (@(posedge clk) disable iff (!rst_int_n)
    !active_o |=> !redir_o);

  // R9: an abort source while active always yields a redirect
  a_r9_abort_wins: assert property (@(posedge clk) disable iff (!rst_int_n)
    (active_o && (ovf_i || conf_i || xabort_i)) |=> redir_o);
endmodule

// File: tb/tb_tx_abort_ctrl.sv
module tb_tx_abort_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        beg_i, commit_i, xabort_i, ovf_i, conf_i, code_we_i;
  logic [31:0] beg_addr_i, sp_i;
  logic [19:0] code_wdata_i;
  logic [1:0]  rd_idx_i;
  logic [31:0] rd_data_o, redir_pc_o, redir_sp_o;
  logic        active_o, redir_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  logic        m_active, m_redir;
  logic [31:0] m_pc, m_sp;
  logic [2:0]  m_cause;
  logic [19:0] m_code;

  always #4 clk = ~clk;

  tx_abort_ctrl dut (
    .clk(clk), .rst_n(rst_n), .beg_i(beg_i), .beg_addr_i(beg_addr_i), .sp_i(sp_i),
    .commit_i(commit_i), .xabort_i(xabort_i), .ovf_i(ovf_i), .conf_i(conf_i),
    .code_we_i(code_we_i), .code_wdata_i(code_wdata_i), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o), .active_o(active_o), .redir_o(redir_o),
    .redir_pc_o(redir_pc_o), .redir_sp_o(redir_sp_o)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] idx);
    case (idx)
      2'd0:    return m_pc;
      2'd1:    return m_sp;
      2'd2:    return {29'd0, m_cause};
      default: return {12'd0, m_code};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    beg_i = 0; commit_i = 0; xabort_i = 0; ovf_i = 0; conf_i = 0; code_we_i = 0;
  endtask

  task automatic model_edge();
    logic ab;
    ab = m_active & (ovf_i | conf_i | xabort_i);
    m_redir = ab;
    if (ab) begin
      m_cause  = {xabort_i, conf_i, ovf_i};
      m_active = 1'b0;
    end else if (m_active && commit_i) begin
      m_active = 1'b0;
    end else if (!m_active && beg_i) begin
      m_active = 1'b1;
      m_pc     = beg_addr_i;
      m_sp     = sp_i;
    end
    if (code_we_i) m_code = code_wdata_i;
  endtask

  // inputs are already set; called at a negedge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2 active", {31'd0, active_o}, {31'd0, m_active});
    chk("R5 redirect", {31'd0, redir_o}, {31'd0, m_redir});
    if (m_redir) begin
      chk("R5 pc", redir_pc_o, m_pc);
      chk("R5 sp", redir_sp_o, m_sp);
    end
    chk("R8 read", rd_data_o, exp_read(rd_idx_i));
    idle_inputs();
  endtask

  task automatic read_chk(input string tag, input logic [1:0] idx, input logic [31:0] exp);
    rd_idx_i = idx;
    #1;
    chk(tag, rd_data_o, exp);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20110907));
    rst_n = 0;
    idle_inputs();
    beg_addr_i = '0; sp_i = '0; code_wdata_i = '0; rd_idx_i = '0;
    m_active = 0; m_redir = 0; m_pc = '0; m_sp = '0; m_cause = '0; m_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 active", {31'd0, active_o}, 32'd0);
    chk("R1 redirect", {31'd0, redir_o}, 32'd0);
    for (int i = 0; i < 4; i++) read_chk("R1 reg", 2'(i), 32'd0);

    // R4: abort sources while idle are ignored
    xabort_i = 1; ovf_i = 1; conf_i = 1; rd_idx_i = 2'd2; step();
    read_chk("R4 cause kept", 2'd2, 32'd0);
    // R3: commit while idle has no effect
    commit_i = 1; step();
    chk("R3 idle commit", {31'd0, active_o}, 32'd0);

    // R2: begin captures; second begin ignored
    beg_i = 1; beg_addr_i = 32'h0000_4000; sp_i = 32'h7FFF_FF00; rd_idx_i = 2'd0; step();
    beg_i = 1; beg_addr_i = 32'hDEAD_0000; sp_i = 32'h1111_1111; step();
    read_chk("R2 pc kept", 2'd0, 32'h0000_4000);
    read_chk("R2 sp kept", 2'd1, 32'h7FFF_FF00);
    // R3: commit closes without redirect
    commit_i = 1; step();
    chk("R3 commit", {30'd0, active_o, redir_o}, 32'd0);

    // R7: code write, then begin + multi-cause abort (R5, R6)
    code_we_i = 1; code_wdata_i = 20'hABCDE; step();
    beg_i = 1; beg_addr_i = 32'h0000_8000; sp_i = 32'h7000_0000; step();
    ovf_i = 1; conf_i = 1; step();
    chk("R5 pulse", {31'd0, redir_o}, 32'd1);
    chk("R5 pc", redir_pc_o, 32'h0000_8000);
    chk("R5 sp", redir_sp_o, 32'h7000_0000);
    read_chk("R6 cause ovf+conf", 2'd2, 32'd3);
    read_chk("R7 code kept", 2'd3, 32'h000A_BCDE);
    step();
    chk("R5 single pulse", {31'd0, redir_o}, 32'd0);

    // R9: commit and explicit abort together
    beg_i = 1; beg_addr_i = 32'h0000_C000; sp_i = 32'h6000_0000; step();
    commit_i = 1; xabort_i = 1; step();
    chk("R9 redirect", {31'd0, redir_o}, 32'd1);
    read_chk("R9 cause expl", 2'd2, 32'd4);
    read_chk("R7 code kept", 2'd3, 32'h000A_BCDE);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      beg_i        = ($urandom % 4) == 0;
      commit_i     = ($urandom % 8) == 0;
      ovf_i        = ($urandom % 16) == 0;
      conf_i       = ($urandom % 10) == 0;
      xabort_i     = ($urandom % 16) == 0;
      code_we_i    = ($urandom % 8) == 0;
      beg_addr_i   = $urandom;
      sp_i         = $urandom;
      code_wdata_i = 20'($urandom);
      rd_idx_i     = 2'($urandom);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule